// File: doc/BRIEF.md
# Multilevel Interrupt Arbiter with Non-Maskable Class

This block sits between a set of peripheral event lines and a small processor core. Every maskable line has a sticky pending flag, a local enable and a two-bit priority level. A separate group of non-maskable lines has its own pending flags and enables. The arbiter picks one winner and waits out a fixed entry latency. It then presents a vector number with a valid signal and holds it until the core acknowledges it. On acknowledge it records the handler's level in a nesting status. A return pulse from the core removes exactly the level that the acknowledge added.

Maskable lines take part only while the global enable input is high. Non-maskable lines ignore that input and never alter it. While a non-maskable handler runs, nothing else is dispatched. After the core writes a valid protection signature, no new dispatch may start for a short window.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on a request line sets its pending flag on the next clock edge, whatever the global enable, local enable or nesting state.
- R2: A one on a bit of the clear input drops that pending flag on the next edge. A set and a clear of the same bit in the same cycle leave the flag set.
- R3: When the core raises `irq_ack` while `irq_valid` is high, the pending flag of the issued line (maskable or non-maskable) clears on that edge, and `irq_valid` falls on the same edge.
- R4: A pending flag stays set while its line is disabled, while the global enable is low, or while a higher-priority handler runs. It is dispatched once the blocking condition is removed.
- R5: Level codes are 0 for low, 1 for medium, 2 for high, and 3 is treated as high. Among eligible maskable lines the highest level wins, and within a level the lowest line index wins.
- R6: A maskable request pre-empts a running handler only if its level is strictly higher than the highest active level. `lvl_active` bit 0 means low is active, bit 1 medium and bit 2 high.
- R7: An enabled non-maskable line is dispatched with the global enable low. A disabled one only stays pending.
- R8: While `nmi_active` is high, `irq_valid` never rises.
- R9: Non-maskable requests win over all maskable ones, and among them the lowest index wins.
- R10: A return pulse clears `nmi_active` if it is set. Otherwise it clears the highest set bit of `lvl_active`, which restores the state from before the latest acknowledge.
- R11: A `sig_ok` pulse blocks the start of any dispatch on that edge and the following three edges.
- R12: Vector 0 is never issued. Non-maskable line i issues vector i+1 and maskable line i issues vector N_NMI+1+i. `irq_valid` rises on the third edge after the pending flag becomes visible, and the vector holds steady until acknowledged.
- R13: After reset all flags, the nesting status and `irq_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie | input | 1 | Global enable for maskable lines |
| req_pulse | input | N_REQ | Maskable event pulses |
| req_en | input | N_REQ | Maskable local enables |
| req_lvl | input | 2*N_REQ | Level code per maskable line, line i at bits 2i+1:2i |
| req_clr | input | N_REQ | Write-one-to-clear for maskable flags |
| nmi_pulse | input | N_NMI | Non-maskable event pulses |
| nmi_en | input | N_NMI | Non-maskable enables |
| nmi_clr | input | N_NMI | Write-one-to-clear for non-maskable flags |
| sig_ok | input | 1 | Valid protection signature written |
| reti | input | 1 | Return-from-handler pulse |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | VEC_W | Vector number |
| pend_flags | output | N_REQ | Maskable pending flags |
| nmi_pend | output | N_NMI | Non-maskable pending flags |
| lvl_active | output | 3 | Active maskable levels {high, med, low} |
| nmi_active | output | 1 | Non-maskable handler running |

## Verification
A flag driven between edges is visible after one edge. With nothing blocking, the vector appears four edges after the pulse was driven, and seven edges after it when a signature is written alongside. The bench stamps the cycle count when it drives the stimulus and when the monitor first sees `irq_valid`, and it compares the difference with these figures. Nesting and flag results are sampled one edge after an acknowledge, return or clear. Every vector is matched in order against a scoreboard queue, so an early or unexpected dispatch shows up as a mismatch.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_WAIT  = 2'd1,
        DS_ISSUE = 2'd2
    } disp_st_e;

    typedef struct packed {
        logic nmi;
        logic high;
        logic med;
        logic low;
    } nest_t;

    // rank: 0 none, 1 low, 2 medium, 3 high
    function automatic logic [1:0] code_rank(input logic [1:0] code);
        return (code == 2'd3) ? 2'd3 : code + 2'd1;
    endfunction

    function automatic logic [1:0] nest_rank(input nest_t n);
        if (n.high) return 2'd3;
        if (n.med)  return 2'd2;
        if (n.low)  return 2'd1;
        return 2'd0;
    endfunction

    function automatic nest_t nest_pop(input nest_t n);
        nest_t r;
        r = n;
        if (r.nmi)       r.nmi  = 1'b0;
        else if (r.high) r.high = 1'b0;
        else if (r.med)  r.med  = 1'b0;
        else             r.low  = 1'b0;
        return r;
    endfunction

    function automatic nest_t nest_push(input nest_t n, input logic is_nmi,
                                        input logic [1:0] rank);
        nest_t r;
        r = n;
        if (is_nmi) r.nmi = 1'b1;
        else begin
            case (rank)
                2'd3:    r.high = 1'b1;
                2'd2:    r.med  = 1'b1;
                default: r.low  = 1'b1;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] sw_clr_i,
    input  logic [W-1:0] ack_clr_i,
    output logic [W-1:0] flags_o
);
    // a new event in the same cycle outranks any clear
    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= (flags_o & ~(sw_clr_i | ack_clr_i)) | set_i;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import lvl_irq_pkg::*;
#(
    parameter int N_REQ = 8,
    parameter int N_NMI = 2,
    parameter int VEC_W = 4,
    parameter int IDX_W = 3
) (
    input  logic [N_REQ-1:0]   m_flag_i,
    input  logic [N_REQ-1:0]   m_en_i,
    input  logic [2*N_REQ-1:0] m_lvl_i,
    input  logic [N_NMI-1:0]   n_flag_i,
    input  logic [N_NMI-1:0]   n_en_i,
    input  logic               gie_i,
    input  nest_t              nest_i,
    output logic               hit_o,
    output logic               win_nmi_o,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic [1:0]         win_rank_o,
    output logic [VEC_W-1:0]   win_vec_o
);
    logic [1:0]       cur;
    logic             m_hit, n_hit, m_ok, n_ok;
    logic [IDX_W-1:0] m_idx, n_idx;
    logic [1:0]       m_rank;

    always_comb begin
        cur    = nest_rank(nest_i);
        m_hit  = 1'b0;
        m_idx  = '0;
        m_rank = 2'd0;
        // levels from the top, lowest index first inside a level
        for (int r = 3; r >= 1; r--) begin
            for (int i = 0; i < N_REQ; i++) begin
                if (!m_hit && m_flag_i[i] && m_en_i[i] &&
                    code_rank(m_lvl_i[2*i +: 2]) == 2'(r) && 2'(r) > cur) begin
                    m_hit  = 1'b1;
                    m_idx  = IDX_W'(i);
                    m_rank = 2'(r);
                end
            end
        end
        n_hit = 1'b0;
        n_idx = '0;
        for (int i = 0; i < N_NMI; i++) begin
            if (!n_hit && n_flag_i[i] && n_en_i[i]) begin
                n_hit = 1'b1;
                n_idx = IDX_W'(i);
            end
        end
        m_ok       = m_hit && gie_i && !nest_i.nmi;
        n_ok       = n_hit && !nest_i.nmi;
        hit_o      = n_ok || m_ok;
        win_nmi_o  = n_ok;
        win_idx_o  = n_ok ? n_idx : m_idx;
        win_rank_o = n_ok ? 2'd0 : m_rank;
        win_vec_o  = n_ok ? (VEC_W'(n_idx) + VEC_W'(1))
                          : (VEC_W'(m_idx) + VEC_W'(N_NMI + 1));
    end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
    import lvl_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push_i,
    input  logic       push_nmi_i,
    input  logic [1:0] push_rank_i,
    input  logic       pop_i,
    output nest_t      nest_o
);
    nest_t nxt;

    always_comb begin
        nxt = nest_o;
        if (pop_i)  nxt = nest_pop(nxt);
        if (push_i) nxt = nest_push(nxt, push_nmi_i, push_rank_i);
    end

    always_ff @(posedge clk) begin
        if (rst) nest_o <= '0;
        else     nest_o <= nxt;
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int N_REQ    = 8,
    parameter int N_NMI    = 2,
    parameter int RESP_CYC = 3,
    parameter int LOCK_CYC = 4,
    localparam int VEC_W   = $clog2(N_NMI + N_REQ + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gie,
    input  logic [N_REQ-1:0]   req_pulse,
    input  logic [N_REQ-1:0]   req_en,
    input  logic [2*N_REQ-1:0] req_lvl,
    input  logic [N_REQ-1:0]   req_clr,
    input  logic [N_NMI-1:0]   nmi_pulse,
    input  logic [N_NMI-1:0]   nmi_en,
    input  logic [N_NMI-1:0]   nmi_clr,
    input  logic               sig_ok,
    input  logic               reti,
    input  logic               irq_ack,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [N_REQ-1:0]   pend_flags,
    output logic [N_NMI-1:0]   nmi_pend,
    output logic [2:0]         lvl_active,
    output logic               nmi_active
);
    localparam int MAXN  = (N_REQ > N_NMI) ? N_REQ : N_NMI;
    localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1;
    localparam int RC_W  = $clog2(RESP_CYC + 1);
    localparam int LK_W  = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        logic             is_nmi;
        logic [IDX_W-1:0] idx;
        logic [1:0]       rank;
        logic [VEC_W-1:0] vec;
    } win_t;

    disp_st_e         st_q;
    logic [RC_W-1:0]  cnt_q;
    logic [LK_W-1:0]  lock_q;
    win_t             win_q;
    nest_t            nest;

    logic             p_hit, p_nmi;
    logic [IDX_W-1:0] p_idx;
    logic [1:0]       p_rank;
    logic [VEC_W-1:0] p_vec;
    logic             blocked, start, take;
    logic [N_REQ-1:0] m_ack_clr;
    logic [N_NMI-1:0] n_ack_clr;

    irq_pend_bank #(.W(N_REQ)) u_mbank (
        .clk(clk), .rst(rst), .set_i(req_pulse), .sw_clr_i(req_clr),
        .ack_clr_i(m_ack_clr), .flags_o(pend_flags)
    );

    irq_pend_bank #(.W(N_NMI)) u_nbank (
        .clk(clk), .rst(rst), .set_i(nmi_pulse), .sw_clr_i(nmi_clr),
        .ack_clr_i(n_ack_clr), .flags_o(nmi_pend)
    );

    irq_pick #(.N_REQ(N_REQ), .N_NMI(N_NMI), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_pick (
        .m_flag_i(pend_flags), .m_en_i(req_en), .m_lvl_i(req_lvl),
        .n_flag_i(nmi_pend), .n_en_i(nmi_en), .gie_i(gie), .nest_i(nest),
        .hit_o(p_hit), .win_nmi_o(p_nmi), .win_idx_o(p_idx),
        .win_rank_o(p_rank), .win_vec_o(p_vec)
    );

    irq_nest u_nest (
        .clk(clk), .rst(rst), .push_i(take), .push_nmi_i(win_q.is_nmi),
        .push_rank_i(win_q.rank), .pop_i(reti), .nest_o(nest)
    );

    assign blocked = sig_ok || (lock_q != '0);
    assign start   = (st_q == DS_IDLE) && p_hit && !blocked;
    assign take    = (st_q == DS_ISSUE) && irq_ack;

    assign m_ack_clr = (take && !win_q.is_nmi) ? (N_REQ'(1) << win_q.idx) : '0;
    assign n_ack_clr = (take &&  win_q.is_nmi) ? (N_NMI'(1) << win_q.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= DS_IDLE;
            cnt_q  <= '0;
            lock_q <= '0;
            win_q  <= '0;
        end else begin
            if (sig_ok)              lock_q <= LK_W'(LOCK_CYC - 1);
            else if (lock_q != '0)   lock_q <= lock_q - 1'b1;

            case (st_q)
                DS_IDLE: begin
                    if (start) begin
                        win_q <= '{is_nmi: p_nmi, idx: p_idx, rank: p_rank, vec: p_vec};
                        cnt_q <= RC_W'(RESP_CYC - 1);
                        st_q  <= (RESP_CYC > 1) ? DS_WAIT : DS_ISSUE;
                    end
                end
                DS_WAIT: begin
                    if (cnt_q <= RC_W'(1)) st_q  <= DS_ISSUE;
                    else                   cnt_q <= cnt_q - 1'b1;
                end
                DS_ISSUE: begin
                    if (irq_ack) st_q <= DS_IDLE;
                end
                default: st_q <= DS_IDLE;
            endcase
        end
    end

    assign irq_valid  = (st_q == DS_ISSUE);
    assign irq_vec    = win_q.vec;
    assign lvl_active = {nest.high, nest.med, nest.low};
    assign nmi_active = nest.nmi;
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
    parameter int N_REQ  = 8,
    parameter int N_NMI  = 2,
    localparam int VEC_W = $clog2(N_NMI + N_REQ + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_REQ-1:0] req_pulse,
    input logic [N_REQ-1:0] req_clr,
    input logic [N_REQ-1:0] pend_flags,
    input logic             reti,
    input logic             irq_ack,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vec,
    input logic [2:0]       lvl_active,
    input logic             nmi_active
);
    p_flag_set_r1: assert property (@(posedge clk) disable iff (rst)
        (|req_pulse) |=> ((pend_flags & $past(req_pulse)) == $past(req_pulse)));

    p_flag_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (|(req_clr & ~req_pulse)) |=> ((pend_flags & $past(req_clr & ~req_pulse)) == '0));

    p_ack_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ack) |=> !irq_valid);

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend_flags) & ~pend_flags & ~$past(req_clr))) |-> $past(irq_valid && irq_ack));

    p_nmi_alone_r8: assert property (@(posedge clk) disable iff (rst)
        nmi_active |-> !irq_valid);

    p_reti_restore_r10: assert property (@(posedge clk) disable iff (rst)
        (reti && nmi_active && !(irq_valid && irq_ack))
        |=> (!nmi_active && lvl_active == $past(lvl_active)));

    p_vec_range_r12: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vec != '0 && irq_vec <= VEC_W'(N_NMI + N_REQ)));

    p_vec_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vec)));
endmodule

bind lvl_irq_ctrl lvl_irq_chk #(.N_REQ(N_REQ), .N_NMI(N_NMI)) u_chk (
    .clk(clk), .rst(rst), .req_pulse(req_pulse), .req_clr(req_clr),
    .pend_flags(pend_flags), .reti(reti), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .lvl_active(lvl_active),
    .nmi_active(nmi_active)
);

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
    localparam int NR = 8;
    localparam int NN = 2;
    localparam int VW = $clog2(NN + NR + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            gie = 1'b0;
    logic [NR-1:0]   req_pulse = '0, req_en = '0, req_clr = '0;
    // line:7 low,6 high,5 high,4 med,3 low,2 low,1 med,0 low
    logic [2*NR-1:0] req_lvl = 16'b00_10_10_01_00_00_01_00;
    logic [NN-1:0]   nmi_pulse = '0, nmi_en = '0, nmi_clr = '0;
    logic            sig_ok = 1'b0, reti = 1'b0, irq_ack = 1'b0;
    logic            irq_valid, nmi_active;
    logic [VW-1:0]   irq_vec;
    logic [NR-1:0]   pend_flags;
    logic [NN-1:0]   nmi_pend;
    logic [2:0]      lvl_active;

    int    cyc = 0, n_chk = 0, n_fail = 0, n_issue = 0, n_exp = 0, last_issue = 0;
    int    exp_vec[$];
    string exp_tag[$];
    string unexp_tag = "R4";

    lvl_irq_ctrl #(.N_REQ(NR), .N_NMI(NN)) u_dut (
        .clk(clk), .rst(rst), .gie(gie), .req_pulse(req_pulse), .req_en(req_en),
        .req_lvl(req_lvl), .req_clr(req_clr), .nmi_pulse(nmi_pulse), .nmi_en(nmi_en),
        .nmi_clr(nmi_clr), .sig_ok(sig_ok), .reti(reti), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .pend_flags(pend_flags),
        .nmi_pend(nmi_pend), .lvl_active(lvl_active), .nmi_active(nmi_active)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard and acknowledges each vector
    always @(negedge clk) begin
        if (irq_valid && !irq_ack) begin
            n_issue++;
            last_issue = cyc;
            if (exp_vec.size() == 0) begin
                chk(1'b0, unexp_tag, int'(irq_vec), 0);
            end else begin
                string t;
                int    v;
                v = exp_vec.pop_front();
                t = exp_tag.pop_front();
                chk(int'(irq_vec) == v, t, int'(irq_vec), v);
            end
            irq_ack = 1'b1;
        end else begin
            irq_ack = 1'b0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NR-1:0] m, input logic [NN-1:0] nm, input logic sg);
        req_pulse = m; nmi_pulse = nm; sig_ok = sg;
        @(negedge clk);
        req_pulse = '0; nmi_pulse = '0; sig_ok = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic do_clr(input logic [NR-1:0] m);
        req_clr = m;
        @(negedge clk);
        req_clr = '0;
    endtask

    task automatic expect_vec(input int v, input string tag);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
        n_exp++;
    endtask

    task automatic wait_all();
        while (n_issue < n_exp) @(negedge clk);
        tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog act=%0d exp=%0d", n_issue, n_exp);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick(1);
        // R13 reset state
        chk(!irq_valid, "R13", int'(irq_valid), 0);
        chk(pend_flags == '0 && nmi_pend == '0, "R13", int'(pend_flags), 0);
        chk(lvl_active == 3'b000 && !nmi_active, "R13", int'(lvl_active), 0);

        // R1 / R4: sticky while disabled and while globally off
        pulse(8'b0000_1000, '0, 1'b0);
        chk(pend_flags[3], "R1", int'(pend_flags), 8);
        tick(8);
        chk(pend_flags[3] && n_issue == 0, "R4", n_issue, 0);
        req_en[3] = 1'b1;
        tick(8);
        chk(n_issue == 0, "R4", n_issue, 0);
        expect_vec(6, "R4");
        gie = 1'b1;
        wait_all();
        chk(!pend_flags[3], "R3", int'(pend_flags), 0);
        chk(lvl_active == 3'b001, "R6", int'(lvl_active), 1);
        do_reti();
        chk(lvl_active == 3'b000, "R10", int'(lvl_active), 0);

        // R12: response latency
        req_en[0] = 1'b1;
        expect_vec(3, "R12");
        k = cyc;
        pulse(8'b0000_0001, '0, 1'b0);
        wait_all();
        chk(last_issue - k == 4, "R12", last_issue - k, 4);
        do_reti();

        // R2: write-one-to-clear, set wins over clear
        gie = 1'b0;
        pulse(8'b0000_0010, '0, 1'b0);
        chk(pend_flags[1], "R1", int'(pend_flags), 2);
        do_clr(8'b0000_0010);
        chk(!pend_flags[1], "R2", int'(pend_flags), 0);
        req_pulse = 8'b0000_0010; req_clr = 8'b0000_0010;
        tick(1);
        req_pulse = '0; req_clr = '0;
        chk(pend_flags[1], "R2", int'(pend_flags), 2);
        do_clr(8'b0000_0010);
        chk(pend_flags == '0, "R2", int'(pend_flags), 0);

        // R5 / R6: level order, strict pre-emption
        req_en = '1;
        pulse(8'b0110_0110, '0, 1'b0);
        expect_vec(8, "R5");
        unexp_tag = "R6";
        gie = 1'b1;
        wait_all();
        tick(10);
        chk(n_issue == n_exp, "R6", n_issue, n_exp);
        chk(lvl_active == 3'b100, "R6", int'(lvl_active), 4);
        expect_vec(9, "R6");
        do_reti();
        wait_all();
        expect_vec(4, "R5");
        do_reti();
        wait_all();
        expect_vec(5, "R5");
        do_reti();
        wait_all();
        do_reti();
        chk(lvl_active == 3'b000 && pend_flags == '0, "R10", int'(lvl_active), 0);

        // R6 / R10: nesting a higher level, blocking an equal one
        expect_vec(5, "R6");
        pulse(8'b0000_0100, '0, 1'b0);
        wait_all();
        pulse(8'b0000_1000, '0, 1'b0);
        tick(8);
        chk(n_issue == n_exp, "R6", n_issue, n_exp);
        expect_vec(8, "R6");
        pulse(8'b0010_0000, '0, 1'b0);
        wait_all();
        chk(lvl_active == 3'b101, "R6", int'(lvl_active), 5);
        do_reti();
        chk(lvl_active == 3'b001, "R10", int'(lvl_active), 1);
        expect_vec(6, "R6");
        do_reti();
        wait_all();
        do_reti();

        // R7 / R8: non-maskable class
        gie = 1'b0;
        pulse('0, 2'b01, 1'b0);
        chk(nmi_pend == 2'b01, "R7", int'(nmi_pend), 1);
        tick(6);
        chk(n_issue == n_exp, "R7", n_issue, n_exp);
        expect_vec(1, "R7");
        nmi_en = 2'b11;
        wait_all();
        chk(nmi_active, "R7", int'(nmi_active), 1);
        chk(nmi_pend == 2'b00, "R3", int'(nmi_pend), 0);
        gie = 1'b1;
        unexp_tag = "R8";
        pulse(8'b0010_0000, 2'b10, 1'b0);
        tick(10);
        chk(n_issue == n_exp, "R8", n_issue, n_exp);
        expect_vec(2, "R9");
        do_reti();
        wait_all();
        chk(nmi_active, "R9", int'(nmi_active), 1);
        expect_vec(8, "R9");
        do_reti();
        wait_all();
        do_reti();

        // R9: simultaneous non-maskable lines and a maskable one
        expect_vec(1, "R9");
        pulse(8'b1000_0000, 2'b11, 1'b0);
        wait_all();
        expect_vec(2, "R9");
        do_reti();
        wait_all();
        expect_vec(10, "R9");
        do_reti();
        wait_all();
        do_reti();

        // R11: protection lockout delays the dispatch start
        unexp_tag = "R11";
        expect_vec(7, "R11");
        k = cyc;
        pulse(8'b0001_0000, '0, 1'b1);
        wait_all();
        chk(last_issue - k == 7, "R11", last_issue - k, 7);
        do_reti();

        tick(4);
        chk(exp_vec.size() == 0, "R5", exp_vec.size(), 0);
        chk(lvl_active == 3'b000 && !nmi_active, "R10", int'(lvl_active), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule